// File: doc/BRIEF.md
# Three-in-a-row ones detector

This block watches a one-bit serial stream, one bit per rising clock edge, and raises a flag when three ones in a row have arrived. A two-bit state register counts how many ones in a row have been seen so far: none, one or two. Next-state and output logic work from that count and the present input bit.

The flag is a Mealy output. It comes from the registered count and the live input with no output register, so it rises in the same cycle that the third one is on the input, before the edge that takes that bit in. Detection does not overlap. After a hit the count goes back to zero, so a fourth one in a row starts a new run and does not raise the flag again. A synchronous active-high reset returns the count to zero.

Top module: `triple_ones_fsm`

## Requirements
- R1: While `rst` is high at a rising edge, the count becomes zero whatever `bit_in` is. After `rst` is released, three more ones are needed before `hit_out` rises.
- R2: `hit_out` is 1 exactly when the registered count is two (encoding 2'b10) and `bit_in` is 1. In every other case it is 0. The encodings are zero = 2'b00, one = 2'b01 and two = 2'b10, and 2'b11 is never entered.
- R3: A 1 sampled at an edge moves the count from zero to one, or from one to two. The flag is therefore high during the cycle in which the third consecutive 1 is driven.
- R4: A 0 sampled at any edge clears the count to zero, so ones split by a zero never produce a hit.
- R5: The edge that samples a detecting 1 returns the count to zero. In an unbroken run of ones, the flag rises on the 3rd, 6th, 9th and later ones, and never on the 4th or 5th.
- R6: The input matters only at the rising edge. A pulse on `bit_in` that is gone before the edge does not change the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to count zero |
| bit_in | input | 1 | Serial input bit |
| hit_out | output | 1 | High while the third consecutive one is present |

## Verification
`hit_out` depends on the current `bit_in` and the count held before the next edge, so each driven bit has its result due in the same cycle, with no added latency. The driver changes `bit_in` just after a falling edge and records the expected flag. The monitor samples a quarter period later, which is well before the rising edge that commits the bit. Every check therefore pairs one driven bit with the flag that bit should produce against the count from earlier edges.

// File: rtl/triple_ones_fsm.sv
module triple_ones_fsm (
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  output logic hit_out
);

  localparam logic [1:0] ST_ZERO = 2'b00;
  localparam logic [1:0] ST_ONE  = 2'b01;
  localparam logic [1:0] ST_TWO  = 2'b10;

  logic [1:0] state_q;
  logic [1:0] state_d;

  assign hit_out = state_q[1] & ~state_q[0] & bit_in;

  always_comb begin
    case (state_q)
      ST_ZERO: state_d = bit_in ? ST_ONE : ST_ZERO;
      ST_ONE:  state_d = bit_in ? ST_TWO : ST_ZERO;
      default: state_d = ST_ZERO;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_ZERO;
    else     state_q <= state_d;
  end

  assert_zero_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> state_q == ST_ZERO);

  assert_legal_state_R2: assert property (@(posedge clk) disable iff (rst)
    state_q != 2'b11);

  assert_first_step_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ZERO && bit_in) |=> state_q == ST_ONE);

  assert_second_step_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ONE && bit_in) |=> state_q == ST_TWO);

  assert_zero_clears_R4: assert property (@(posedge clk) disable iff (rst)
    !bit_in |=> state_q == ST_ZERO);

  assert_hit_restarts_R5: assert property (@(posedge clk) disable iff (rst)
    hit_out |=> (state_q == ST_ZERO && !hit_out));

endmodule

// File: tb/triple_ones_fsm_tb_top.sv
module triple_ones_fsm_tb_top;
  localparam int PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_in = 1'b0;
  logic hit_out;

  int checks = 0;
  int errors = 0;
  int cnt = 0;
  bit done = 1'b0;

  logic  exp_q[$];
  string tag_q[$];

  always #(PERIOD/2) clk = ~clk;

  triple_ones_fsm dut_i (.clk(clk), .rst(rst), .bit_in(bit_in), .hit_out(hit_out));

  task automatic push_exp(input logic v, input string tag);
    exp_q.push_back((cnt == 2) && v);
    tag_q.push_back(tag);
    if (rst)      cnt = 0;
    else if (!v)  cnt = 0;
    else          cnt = (cnt == 2) ? 0 : cnt + 1;
  endtask

  task automatic step(input logic v, input logic r, input string tag);
    @(negedge clk);
    bit_in = v;
    rst = r;
    push_exp(v, tag);
  endtask

  task automatic glitch_low(input string tag);
    @(negedge clk);
    rst = 1'b0;
    bit_in = 1'b0;
    #(PERIOD/8);
    bit_in = 1'b1;
    push_exp(1'b1, tag);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #(PERIOD/4);
      if (exp_q.size() > 0) begin
        logic  e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if (hit_out !== e) begin
          errors++;
          $display("FAIL %s: hit_out=%b expected=%b at %0t", t, hit_out, e, $time);
        end
      end
    end
  end

  initial begin
    #(PERIOD * 5000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    @(posedge clk);
    cnt = 0;
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, "R1");
    step(1'b1, 1'b0, "R1");
    step(1'b1, 1'b0, "R1");
    step(1'b1, 1'b0, "R3");
    step(1'b0, 1'b0, "R2");
    step(1'b1, 1'b0, "R2");
    step(1'b1, 1'b0, "R2");
    step(1'b0, 1'b0, "R2");
    for (int i = 0; i < 9; i++) step(1'b1, 1'b0, "R5");
    step(1'b0, 1'b0, "R4");
    step(1'b1, 1'b0, "R4");
    step(1'b1, 1'b0, "R4");
    step(1'b0, 1'b0, "R4");
    step(1'b1, 1'b0, "R4");
    step(1'b0, 1'b0, "R4");
    step(1'b1, 1'b0, "R4");
    step(1'b1, 1'b0, "R4");
    step(1'b1, 1'b0, "R3");
    step(1'b1, 1'b0, "R6");
    glitch_low("R6");
    glitch_low("R6");
    step(1'b0, 1'b0, "R6");
    step(1'b1, 1'b0, "R1");
    step(1'b1, 1'b0, "R1");
    step(1'b1, 1'b1, "R1");
    step(1'b1, 1'b0, "R1");
    step(1'b1, 1'b0, "R1");
    step(1'b1, 1'b0, "R1");
    step(1'b0, 1'b0, "R2");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule